// File: doc/BRIEF.md
# Acquisition Trigger and Arm Controller

This block decides when a multi-lane acquisition engine begins capturing a packet. It watches a hardware trigger, a trigger from a neighbouring controller, and two arm sources. It issues a single-cycle start pulse to the lane packetizers. The start pulse carries two flags: one says whether a metadata header is wanted, and one says whether the packet is to be discarded downstream because freeze was active.

There are two capture modes. In continuous mode, every trigger edge starts a packet. In triggered mode, a trigger only starts a packet after an arm. The controller then disarms itself, and with auto re-arm set it arms itself again each time a packet completes. Two outputs repeat the software trigger and arm settings so that a chained controller can fire together with this one. Sticky status bits record a link that is not ready and a start that was refused because of pause. A saturating counter records triggers that arrived while a packet was still in progress.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After reset, `start_o`, `armed_o`, `busy_o`, `stream_err_o`, `pause_err_o` and `overrun_cnt_o` are all 0.
- R2: With `cfg_mode_i`=0 (continuous), a trigger edge while idle and not paused raises `start_o` for exactly one cycle, in the cycle after the edge is sampled, and sets `busy_o`; `pkt_done_i` clears `busy_o`.
- R3: With `cfg_mode_i`=1 (triggered), a trigger is ignored when not armed; when armed, exactly one packet starts and `armed_o` drops to 0.
- R4: With `cfg_auto_rearm_i`=1 in triggered mode, `armed_o` returns to 1 in the cycle after `pkt_done_i` is sampled.
- R5: A rising edge on `casc_trig_i` acts as a trigger only while `cfg_casc_en_i`=1; the effective trigger is the OR of the enabled sources.
- R6: A rising edge on `casc_arm_i` or on `cfg_arm_i` sets `armed_o`.
- R7: `casc_trig_o` follows `cfg_sw_trig_i` and `casc_arm_o` follows `cfg_arm_i`.
- R8: `start_invalid_o` carries the value of `freeze_i` from the start cycle; freeze never blocks a start.
- R9: Any `link_ready_i` bit at 0 sets `stream_err_o` on the next cycle, and the bit stays set until reset.
- R10: If `pause_i`=1 when a start would occur, no start is issued and `pause_err_o` is set, sticky until reset.
- R11: `start_hdr_o` carries `cfg_hdr_en_i` from the start cycle.
- R12: A trigger while `busy_o`=1 starts nothing and increments `overrun_cnt_o` by one, saturating at its maximum.
- R13: Trigger and arm inputs are edge detected, so a level held high produces only one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_trig_i | input | 1 | Hardware trigger |
| casc_trig_i | input | 1 | Trigger from the upstream controller |
| casc_arm_i | input | 1 | Arm from the upstream controller |
| freeze_i | input | 1 | Marks packets that start now as invalid |
| link_ready_i | input | N_LANES | Per-lane source ready flags |
| pause_i | input | 1 | Downstream pause flag |
| pkt_done_i | input | 1 | Current packet has completed |
| cfg_mode_i | input | 1 | 0 continuous, 1 triggered |
| cfg_casc_en_i | input | 1 | Enables the cascade trigger input |
| cfg_auto_rearm_i | input | 1 | Re-arm after each packet completes |
| cfg_arm_i | input | 1 | Software arm; a rising edge arms |
| cfg_sw_trig_i | input | 1 | Software trigger level for the chain |
| cfg_hdr_en_i | input | 1 | Request a metadata header |
| start_o | output | 1 | Start pulse for the packetizers |
| start_hdr_o | output | 1 | Header flag that goes with the start |
| start_invalid_o | output | 1 | Invalid flag that goes with the start |
| busy_o | output | 1 | A packet is in progress |
| armed_o | output | 1 | Armed for triggered mode |
| casc_trig_o | output | 1 | Trigger to the downstream controller |
| casc_arm_o | output | 1 | Arm to the downstream controller |
| stream_err_o | output | 1 | Sticky link-not-ready error |
| pause_err_o | output | 1 | Sticky start-refused-by-pause error |
| overrun_cnt_o | output | OVR_W | Count of triggers that arrived while busy |

## Verification
The cascade outputs are combinational, so they are checked in the same cycle that the setting changes. Every other result is registered once. A trigger or arm edge sampled at a clock edge changes `start_o`, `busy_o`, `armed_o`, the status bits and the counter right after that edge. `start_o` has fallen again by the following edge. The bench drives inputs and reads outputs one nanosecond after each rising edge. Each check is placed on the step right after the edge that samples its stimulus. The check one step later confirms that the start lasts a single cycle and that held levels cause nothing more.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  typedef enum logic {
    MODE_CONT = 1'b0,
    MODE_TRIG = 1'b1
  } acq_mode_e;

  localparam int unsigned EV_HW_TRIG   = 0;
  localparam int unsigned EV_CASC_TRIG = 1;
  localparam int unsigned EV_CASC_ARM  = 2;
  localparam int unsigned EV_SW_ARM    = 3;
  localparam int unsigned EV_NUM       = 4;
endpackage

// File: rtl/acq_edge_det.sv
module acq_edge_det #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];

    // R13
    single_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/acq_capture_fsm.sv
module acq_capture_fsm
  import acq_trig_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      trig_ev_i,
  input  logic      arm_ev_i,
  input  acq_mode_e mode_i,
  input  logic      auto_rearm_i,
  input  logic      pause_i,
  input  logic      freeze_i,
  input  logic      hdr_en_i,
  input  logic      pkt_done_i,
  output logic      start_o,
  output logic      hdr_o,
  output logic      invalid_o,
  output logic      busy_o,
  output logic      armed_o,
  output logic      overrun_ev_o,
  output logic      pause_blk_o
);
  logic busy_q, armed_q, start_q, hdr_q, inv_q;
  logic eligible, fire;

  assign eligible     = trig_ev_i & ~busy_q & ((mode_i == MODE_CONT) | armed_q);
  assign fire         = eligible & ~pause_i;
  assign pause_blk_o  = eligible & pause_i;
  assign overrun_ev_o = trig_ev_i & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      start_q <= 1'b0;
      hdr_q   <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      start_q <= fire;
      if (fire) begin
        hdr_q <= hdr_en_i;
        inv_q <= freeze_i;
      end
      if (fire)            busy_q <= 1'b1;
      else if (pkt_done_i) busy_q <= 1'b0;
      // arm edge wins over the disarm that a start causes
      if (arm_ev_i)
        armed_q <= 1'b1;
      else if (fire && mode_i == MODE_TRIG)
        armed_q <= 1'b0;
      else if (pkt_done_i && busy_q && auto_rearm_i && mode_i == MODE_TRIG)
        armed_q <= 1'b1;
    end
  end

  assign start_o   = start_q;
  assign hdr_o     = start_q & hdr_q;
  assign invalid_o = start_q & inv_q;
  assign busy_o    = busy_q;
  assign armed_o   = armed_q;

  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  // R2
  start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> busy_q);
  // R12
  no_start_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_ev_i && busy_q) |=> !start_q);
  // R10
  no_start_paused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> !start_q);
  // R3
  disarm_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && mode_i == MODE_TRIG && !arm_ev_i) |=> !armed_q);
endmodule

// File: rtl/acq_status.sv
module acq_status #(
  parameter int unsigned N_LANES = 4,
  parameter int unsigned OVR_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LANES-1:0] link_ready_i,
  input  logic               pause_blk_i,
  input  logic               overrun_ev_i,
  output logic               stream_err_o,
  output logic               pause_err_o,
  output logic [OVR_W-1:0]   overrun_cnt_o
);
  localparam logic [OVR_W-1:0] OVR_MAX = {OVR_W{1'b1}};

  logic             stream_err_q, pause_err_q;
  logic [OVR_W-1:0] ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stream_err_q <= 1'b0;
      pause_err_q  <= 1'b0;
      ovr_q        <= '0;
    end else begin
      if (!(&link_ready_i)) stream_err_q <= 1'b1;
      if (pause_blk_i)      pause_err_q  <= 1'b1;
      if (overrun_ev_i && ovr_q != OVR_MAX) ovr_q <= ovr_q + 1'b1;
    end
  end

  assign stream_err_o  = stream_err_q;
  assign pause_err_o   = pause_err_q;
  assign overrun_cnt_o = ovr_q;

  // R9
  stream_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stream_err_q |=> stream_err_q);
  // R10
  pause_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_err_q |=> pause_err_q);
  // R12
  ovr_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q == OVR_MAX) |=> (ovr_q == OVR_MAX));
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int unsigned N_LANES = 4,
  parameter int unsigned OVR_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hw_trig_i,
  input  logic               casc_trig_i,
  input  logic               casc_arm_i,
  input  logic               freeze_i,
  input  logic [N_LANES-1:0] link_ready_i,
  input  logic               pause_i,
  input  logic               pkt_done_i,
  input  logic               cfg_mode_i,
  input  logic               cfg_casc_en_i,
  input  logic               cfg_auto_rearm_i,
  input  logic               cfg_arm_i,
  input  logic               cfg_sw_trig_i,
  input  logic               cfg_hdr_en_i,
  output logic               start_o,
  output logic               start_hdr_o,
  output logic               start_invalid_o,
  output logic               busy_o,
  output logic               armed_o,
  output logic               casc_trig_o,
  output logic               casc_arm_o,
  output logic               stream_err_o,
  output logic               pause_err_o,
  output logic [OVR_W-1:0]   overrun_cnt_o
);
  logic [EV_NUM-1:0] lvl, rise;
  logic trig_ev, arm_ev, overrun_ev, pause_blk;

  assign lvl[EV_HW_TRIG]   = hw_trig_i;
  assign lvl[EV_CASC_TRIG] = casc_trig_i;
  assign lvl[EV_CASC_ARM]  = casc_arm_i;
  assign lvl[EV_SW_ARM]    = cfg_arm_i;

  acq_edge_det #(.WIDTH(EV_NUM)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  assign trig_ev = rise[EV_HW_TRIG] | (cfg_casc_en_i & rise[EV_CASC_TRIG]);
  assign arm_ev  = rise[EV_CASC_ARM] | rise[EV_SW_ARM];

  acq_capture_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_ev_i    (trig_ev),
    .arm_ev_i     (arm_ev),
    .mode_i       (acq_mode_e'(cfg_mode_i)),
    .auto_rearm_i (cfg_auto_rearm_i),
    .pause_i      (pause_i),
    .freeze_i     (freeze_i),
    .hdr_en_i     (cfg_hdr_en_i),
    .pkt_done_i   (pkt_done_i),
    .start_o      (start_o),
    .hdr_o        (start_hdr_o),
    .invalid_o    (start_invalid_o),
    .busy_o       (busy_o),
    .armed_o      (armed_o),
    .overrun_ev_o (overrun_ev),
    .pause_blk_o  (pause_blk)
  );

  acq_status #(.N_LANES(N_LANES), .OVR_W(OVR_W)) u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .link_ready_i  (link_ready_i),
    .pause_blk_i   (pause_blk),
    .overrun_ev_i  (overrun_ev),
    .stream_err_o  (stream_err_o),
    .pause_err_o   (pause_err_o),
    .overrun_cnt_o (overrun_cnt_o)
  );

  assign casc_trig_o = cfg_sw_trig_i;
  assign casc_arm_o  = cfg_arm_i;

  // R5
  casc_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_casc_en_i && !hw_trig_i && !busy_o) |=> !start_o);
  // R6
  arm_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(casc_arm_i) || $rose(cfg_arm_i)) |=> armed_o);
endmodule

// File: tb/tb_acq_trig_ctrl.sv
module tb_acq_trig_ctrl;
  localparam int unsigned N_LANES = 4;
  localparam int unsigned OVR_W   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_trig = 0, casc_trig = 0, casc_arm = 0, freeze = 0, pause = 0, pkt_done = 0;
  logic [N_LANES-1:0] link_ready = '1;
  logic mode = 0, casc_en = 0, auto_rearm = 0, sw_arm = 0, sw_trig = 0, hdr_en = 0;
  logic start, start_hdr, start_inv, busy, armed, ctrig_o, carm_o, serr, perr;
  logic [OVR_W-1:0] ovr;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  acq_trig_ctrl #(.N_LANES(N_LANES), .OVR_W(OVR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_trig_i(hw_trig), .casc_trig_i(casc_trig),
    .casc_arm_i(casc_arm), .freeze_i(freeze), .link_ready_i(link_ready),
    .pause_i(pause), .pkt_done_i(pkt_done), .cfg_mode_i(mode),
    .cfg_casc_en_i(casc_en), .cfg_auto_rearm_i(auto_rearm), .cfg_arm_i(sw_arm),
    .cfg_sw_trig_i(sw_trig), .cfg_hdr_en_i(hdr_en), .start_o(start),
    .start_hdr_o(start_hdr), .start_invalid_o(start_inv), .busy_o(busy),
    .armed_o(armed), .casc_trig_o(ctrig_o), .casc_arm_o(carm_o),
    .stream_err_o(serr), .pause_err_o(perr), .overrun_cnt_o(ovr)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_pkt();
    pkt_done = 1; step(); pkt_done = 0;
  endtask

  task automatic t_reset();
    chk("R1", "start", start, 0); chk("R1", "armed", armed, 0);
    chk("R1", "busy", busy, 0);   chk("R1", "stream_err", serr, 0);
    chk("R1", "pause_err", perr, 0); chk("R1", "overrun", ovr, 0);
  endtask

  task automatic t_continuous();
    mode = 0; hdr_en = 1;
    hw_trig = 1; step();
    chk("R2", "start", start, 1); chk("R2", "busy", busy, 1);
    chk("R11", "hdr", start_hdr, 1);
    step();
    chk("R2", "start one cycle", start, 0);
    chk("R13", "held trig no event", ovr, 0);
    hw_trig = 0; step();
    hw_trig = 1; step();           // overrun
    chk("R12", "no start busy", start, 0); chk("R12", "overrun", ovr, 1);
    hw_trig = 0; finish_pkt();
    chk("R2", "busy cleared", busy, 0);
    hdr_en = 0; hw_trig = 1; step();
    chk("R2", "restart", start, 1); chk("R11", "hdr off", start_hdr, 0);
    step(); step();
    chk("R13", "held level one start", start, 0);
    finish_pkt(); step();
    chk("R13", "held after done", start, 0);
    hw_trig = 0; step();
  endtask

  task automatic t_triggered();
    mode = 1; auto_rearm = 0;
    hw_trig = 1; step();
    chk("R3", "unarmed ignored", start, 0);
    hw_trig = 0; sw_arm = 1; step();
    chk("R6", "sw arm", armed, 1);
    sw_arm = 0; hw_trig = 1; step();
    chk("R3", "armed start", start, 1); chk("R3", "disarmed", armed, 0);
    hw_trig = 0; step(); finish_pkt();
    chk("R3", "no rearm", armed, 0);
    hw_trig = 1; step();
    chk("R3", "second trig ignored", start, 0);
    hw_trig = 0; step();
  endtask

  task automatic t_auto_rearm();
    mode = 1; auto_rearm = 1;
    casc_arm = 1; step();
    chk("R6", "casc arm", armed, 1);
    casc_arm = 0; hw_trig = 1; step();
    chk("R4", "start", start, 1); chk("R4", "disarmed", armed, 0);
    hw_trig = 0; step(); finish_pkt();
    chk("R4", "rearmed", armed, 1);
    hw_trig = 1; step();
    chk("R4", "second start", start, 1);
    hw_trig = 0; step(); finish_pkt();
    auto_rearm = 0; mode = 0; step();
  endtask

  task automatic t_cascade();
    mode = 0; casc_en = 0;
    casc_trig = 1; step();
    chk("R5", "disabled casc", start, 0);
    casc_trig = 0; casc_en = 1; step();
    casc_trig = 1; step();
    chk("R5", "enabled casc", start, 1);
    casc_trig = 0; step(); finish_pkt();
    casc_en = 0;
    sw_trig = 1; sw_arm = 1; #1;
    chk("R7", "casc_trig_o", ctrig_o, 1); chk("R7", "casc_arm_o", carm_o, 1);
    sw_trig = 0; sw_arm = 0; #1;
    chk("R7", "casc_trig_o low", ctrig_o, 0); chk("R7", "casc_arm_o low", carm_o, 0);
    step();
  endtask

  task automatic t_freeze();
    mode = 0; freeze = 1; hw_trig = 1; step();
    chk("R8", "start under freeze", start, 1); chk("R8", "invalid", start_inv, 1);
    hw_trig = 0; freeze = 0; step(); finish_pkt();
    hw_trig = 1; step();
    chk("R8", "valid", start_inv, 0);
    hw_trig = 0; step(); finish_pkt();
  endtask

  task automatic t_pause();
    mode = 0; pause = 1; hw_trig = 1; step();
    chk("R10", "no start", start, 0); chk("R10", "pause_err", perr, 1);
    chk("R10", "not busy", busy, 0);
    hw_trig = 0; pause = 0; step();
    chk("R10", "sticky", perr, 1);
  endtask

  task automatic t_stream_err();
    chk("R9", "clear", serr, 0);
    link_ready = 4'b1011; step();
    chk("R9", "set", serr, 1);
    link_ready = '1; step(); step();
    chk("R9", "sticky", serr, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1; t_reset();
    repeat (2) @(posedge clk); #1;
    rst_n = 1; step();
    t_reset();
    t_continuous();
    t_triggered();
    t_auto_rearm();
    t_cascade();
    t_freeze();
    t_pause();
    t_stream_err();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule